// File: doc/BRIEF.md
# Serial Management Slave with Interrupt Aggregation

This block is the PHY end of a two-wire Clause 22 management link. It oversamples the management clock (MDC) and the data line (MDIO) with the system clock. It decodes read and write frames sent to its own PHY address and answers reads by driving MDIO through the turnaround and data bits. Behind the serial engine is a small register file. It holds the seven standard registers (addresses 0 to 6), whose reset values and writable bits are parameters. It also holds two vendor registers: the interrupt source flags at `SRC_ADDR` (default 29) and the interrupt enables at `MASK_ADDR` (default 30).

Status events from the rest of the PHY arrive as one-cycle pulses and set sticky flags. A management read of the source register returns the flags and clears them. The flags that are enabled are OR-ed into one level interrupt. The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain control or status signal, and back-pressure does not apply.

Top module: `mdio_phy_irq`

## Requirements
- R1: After reset, a read of registers 0 to 6 returns the parameter reset values: 3100h, 7809h, 0007h, C0D1h, 01E1h, 0000h, 0000h with the defaults.
- R2: A write to registers 0 to 6 changes only the bits set in that register's writable mask (defaults FF80h for register 0, 3FFFh for register 4, none for the others). All other bits keep their value.
- R3: A read of an address that holds no register returns FFFFh.
- R4: Source flags are bits 1 to 7 of the source register. A pulse on `evt[k]` with k in 1..7 sets bit k, and the bit stays set. `evt[0]` and bits 0 and 8 to 15 always read zero.
- R5: A read of the source register returns the flags as they were, then clears them.
- R6: An event that arrives in the same cycle as the clearing read leaves its flag set after the read.
- R7: The enable register keeps bits 1 to 7 of a written value; all other bits read zero. `irq` is high exactly when some flag is set and its enable bit is 1.
- R8: A write to the source register leaves the flags unchanged.
- R9: A frame whose 5-bit PHY address differs from `PHY_ADDR` never drives MDIO and changes no register.
- R10: A frame needs at least 32 ones, then start bits 0,1, then an opcode of 10 (read) or 01 (write). A frame with a shorter preamble or any other opcode is ignored, and the slave waits for the next preamble.
- R11: On a read, MDIO is released for the first turnaround bit and driven 0 for the second. The 16 data bits follow MSB first, each changing after an MDC rising edge, and the output enable drops at the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples MDC and MDIO |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable (1 = slave drives) |
| evt | input | 8 | One-cycle event pulses; bit k sets source flag k (bit 0 unused) |
| irq | output | 1 | Level interrupt: any enabled flag set |

## Verification
The clearing read of the source register and a fresh event pulse can land on the same clock edge. The bench forces this by timing an event pulse to the exact cycle in which the slave latches the read data, two system clocks after the synchronised MDC rise of the last register-address bit. It then expects the read to return the old flags, while the new flag survives and shows up in a second read and in `irq`. The reference model tracks the flags, the enables and `irq` on every clock, so any slip of one cycle in clearing or setting a flag appears as an `irq` mismatch.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    S_PRE, S_ST, S_OP, S_PHY, S_REG, S_TA1, S_TA2, S_DAT
  } mdio_st_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [15:0] FLAG_BITS = 16'h00FE;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio,
  output logic rise,
  output logic bit_o
);
  logic [STAGES:0]   mdc_sh;
  logic [STAGES-1:0] dat_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_sh <= '0;
      dat_sh <= '1;
    end else begin
      mdc_sh <= {mdc_sh[STAGES-1:0], mdc};
      dat_sh <= {dat_sh[STAGES-2:0], mdio};
    end
  end

  assign rise  = mdc_sh[STAGES-1] & ~mdc_sh[STAGES];
  assign bit_o = dat_sh[STAGES-1];
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd1,
  parameter int         PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise,
  input  logic        bit_i,
  input  logic [15:0] rd_data,
  output logic        rd_stb,
  output logic        wr_stb,
  output logic [4:0]  acc_addr,
  output logic [15:0] wr_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] PRE_CNT = CW'(PRE_LEN);
  localparam logic [CW-1:0] LAST5   = CW'(4);
  localparam logic [CW-1:0] LAST16  = CW'(15);

  mdio_st_e      st;
  logic [CW-1:0] cnt;
  logic          op_hi, is_rd;
  logic [4:0]    phy_q, reg_q;
  logic [15:0]   sh;

  assign acc_addr = (st == S_REG) ? {reg_q[3:0], bit_i} : reg_q;
  assign wr_data  = {sh[14:0], bit_i};
  assign rd_stb   = rise && st == S_REG && cnt == LAST5 && phy_q == PHY_ADDR && is_rd;
  assign wr_stb   = rise && st == S_DAT && cnt == LAST16 && !is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PRE; cnt <= '0; op_hi <= 1'b0; is_rd <= 1'b0;
      phy_q <= '0; reg_q <= '0; sh <= '0; mdio_o <= 1'b0; mdio_oe <= 1'b0;
    end else if (rise) begin
      unique case (st)
        S_PRE: begin
          if (bit_i) begin
            if (cnt != PRE_CNT) cnt <= cnt + 1'b1;
          end else begin
            if (cnt == PRE_CNT) st <= S_ST;
            cnt <= '0;
          end
        end
        S_ST: begin
          cnt <= '0;
          st  <= bit_i ? S_OP : S_PRE;
        end
        S_OP: begin
          op_hi <= bit_i;
          if (cnt == CW'(1)) begin
            cnt <= '0;
            if ({op_hi, bit_i} == OP_RD) begin
              is_rd <= 1'b1; st <= S_PHY;
            end else if ({op_hi, bit_i} == OP_WR) begin
              is_rd <= 1'b0; st <= S_PHY;
            end else begin
              st <= S_PRE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PHY: begin
          phy_q <= {phy_q[3:0], bit_i};
          if (cnt == LAST5) begin
            cnt <= '0; st <= S_REG;
          end else cnt <= cnt + 1'b1;
        end
        S_REG: begin
          reg_q <= {reg_q[3:0], bit_i};
          if (cnt == LAST5) begin
            cnt <= '0;
            if (phy_q == PHY_ADDR) begin
              st <= S_TA1;
              if (is_rd) sh <= rd_data;
            end else st <= S_PRE;
          end else cnt <= cnt + 1'b1;
        end
        S_TA1: begin
          st <= S_TA2;
          if (is_rd) begin
            mdio_oe <= 1'b1; mdio_o <= 1'b0;
          end
        end
        S_TA2: begin
          st <= S_DAT; cnt <= '0;
          if (is_rd) begin
            mdio_o <= sh[15]; sh <= {sh[14:0], 1'b0};
          end
        end
        S_DAT: begin
          if (cnt == LAST16) begin
            st <= S_PRE; cnt <= '0; mdio_oe <= 1'b0; mdio_o <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
            if (is_rd) begin
              mdio_o <= sh[15]; sh <= {sh[14:0], 1'b0};
            end
          end
          if (!is_rd) sh <= {sh[14:0], bit_i};
        end
        default: st <= S_PRE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int           NSTD      = 7,
  parameter logic [4:0]   SRC_ADDR  = 5'd29,
  parameter logic [4:0]   MASK_ADDR = 5'd30,
  parameter logic [111:0] STD_RESET = 112'h0,
  parameter logic [111:0] STD_WMASK = 112'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  evt,
  input  logic        rd_stb,
  input  logic        wr_stb,
  input  logic [4:0]  acc_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic [15:0] src_q,
  output logic [15:0] mask_q,
  output logic        irq
);
  logic [15:0] std_q [NSTD];
  logic        src_rd;

  assign src_rd = rd_stb && acc_addr == SRC_ADDR;

  for (genvar i = 0; i < NSTD; i++) begin : g_std
    localparam logic [15:0] RV = STD_RESET[i*16 +: 16];
    localparam logic [15:0] WM = STD_WMASK[i*16 +: 16];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) std_q[i] <= RV;
      else if (wr_stb && acc_addr == 5'(i))
        std_q[i] <= (std_q[i] & ~WM) | (wr_data & WM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
    end else begin
      src_q <= (src_rd ? 16'h0 : src_q) | ({8'h00, evt} & FLAG_BITS);
      if (wr_stb && acc_addr == MASK_ADDR) mask_q <= wr_data & FLAG_BITS;
    end
  end

  always_comb begin
    rd_data = 16'hFFFF;
    if (acc_addr < 5'(NSTD))       rd_data = std_q[acc_addr[2:0]];
    else if (acc_addr == SRC_ADDR)  rd_data = src_q;
    else if (acc_addr == MASK_ADDR) rd_data = mask_q;
  end

  assign irq = |(src_q & mask_q);
endmodule

// File: rtl/mdio_phy_irq.sv
module mdio_phy_irq
  import mdio_pkg::*;
#(
  parameter logic [4:0]   PHY_ADDR  = 5'd1,
  parameter logic [4:0]   SRC_ADDR  = 5'd29,
  parameter logic [4:0]   MASK_ADDR = 5'd30,
  parameter int           PRE_LEN   = 32,
  parameter int           SYNC      = 2,
  parameter logic [111:0] STD_RESET = {16'h0000, 16'h0000, 16'h01E1, 16'hC0D1,
                                       16'h0007, 16'h7809, 16'h3100},
  parameter logic [111:0] STD_WMASK = {16'h0000, 16'h0000, 16'h3FFF, 16'h0000,
                                       16'h0000, 16'h0000, 16'hFF80}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mdc,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic [7:0] evt,
  output logic       irq
);
  logic        rise, bit_s, rd_stb, wr_stb;
  logic [4:0]  acc_addr;
  logic [15:0] wr_data, rd_data, src_q, mask_q;

  mdio_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio(mdio_i), .rise(rise), .bit_o(bit_s)
  );

  mdio_frame #(.PHY_ADDR(PHY_ADDR), .PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n), .rise(rise), .bit_i(bit_s), .rd_data(rd_data),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .acc_addr(acc_addr), .wr_data(wr_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_regs #(.NSTD(7), .SRC_ADDR(SRC_ADDR), .MASK_ADDR(MASK_ADDR),
              .STD_RESET(STD_RESET), .STD_WMASK(STD_WMASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .acc_addr(acc_addr), .wr_data(wr_data), .rd_data(rd_data),
    .src_q(src_q), .mask_q(mask_q), .irq(irq)
  );
endmodule

// File: rtl/mdio_phy_irq_chk.sv
module mdio_phy_irq_chk #(
  parameter logic [4:0] SRC_ADDR = 5'd29
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  evt,
  input logic [15:0] src_q,
  input logic        rd_stb,
  input logic        wr_stb,
  input logic [4:0]  acc_addr,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        irq
);
  // R4 / R6: every event pulse leaves its flag set on the next cycle
  p_evt_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & 8'hFE)) |=> ((src_q[7:0] & $past(evt & 8'hFE)) == $past(evt & 8'hFE)));

  // R5: a clearing read leaves only flags from events of that same cycle
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && acc_addr == SRC_ADDR) |=> ((src_q[7:0] & ~$past(evt & 8'hFE)) == 8'h00));

  // R8: writing the source register does not alter it
  p_src_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && acc_addr == SRC_ADDR) |=>
      (src_q == ($past(src_q) | {8'h00, $past(evt & 8'hFE)})));

  // R11: when the slave takes the line it first drives a zero
  p_turnaround_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R7: irq can only rise after an event or a register write
  p_irq_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|evt) || $past(wr_stb)));
endmodule

bind mdio_phy_irq mdio_phy_irq_chk #(.SRC_ADDR(SRC_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .src_q(src_q), .rd_stb(rd_stb),
  .wr_stb(wr_stb), .acc_addr(acc_addr), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq(irq)
);

// File: tb/mdio_phy_irq_test.sv
module mdio_phy_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam logic [4:0] PHY = 5'd1;
  localparam logic [4:0] SRC = 5'd29;
  localparam logic [4:0] MSK = 5'd30;

  logic clk = 0, rst_n = 0, mdc = 0, m_drv = 1, m_bit = 1;
  logic [7:0] evt = 0;
  logic mdio_o, mdio_oe, irq, line;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign line = mdio_oe ? mdio_o : (m_drv ? m_bit : 1'b1);

  mdio_phy_irq uut (.clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .evt(evt), .irq(irq));

  // behavioural reference model
  logic [15:0] m_std [7];
  logic [15:0] m_wm  [7];
  logic [15:0] m_src, m_msk;
  int cyc = 0, clr_at = -1, wr_at = -1;
  logic [4:0] wr_a; logic [15:0] wr_d;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_std[0] = 16'h3100; m_std[1] = 16'h7809; m_std[2] = 16'h0007; m_std[3] = 16'hC0D1;
      m_std[4] = 16'h01E1; m_std[5] = 16'h0000; m_std[6] = 16'h0000;
      foreach (m_wm[i]) m_wm[i] = 16'h0;
      m_wm[0] = 16'hFF80; m_wm[4] = 16'h3FFF;
      m_src = 0; m_msk = 0;
    end else begin
      if (cyc == clr_at) m_src = 0;
      m_src = m_src | ({8'h0, evt} & 16'h00FE);
      if (cyc == wr_at) begin
        if (wr_a < 7) m_std[wr_a] = (m_std[wr_a] & ~m_wm[wr_a]) | (wr_d & m_wm[wr_a]);
        else if (wr_a == MSK) m_msk = wr_d & 16'h00FE;
      end
    end
    cyc = cyc + 1;
  end

  function automatic logic [15:0] m_read(input logic [4:0] a);
    if (a < 7) return m_std[a];
    if (a == SRC) return m_src;
    if (a == MSK) return m_msk;
    return 16'hFFFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R7: irq compared with the model on every clock
  always @(negedge clk) if (rst_n && !done) chk("R7 irq", {31'h0, irq}, {31'h0, |(m_src & m_msk)});

  // one MDC period; hook 1 = clearing read edge, hook 2 = write commit edge
  task automatic mbit(input logic drv, input logic b, input int hook, input logic [7:0] hev,
                      output logic smp, output logic oe_s);
    @(negedge clk); mdc = 0; m_drv = drv; m_bit = b;
    repeat (HALF-1) @(negedge clk);
    smp = line; oe_s = mdio_oe;
    @(negedge clk); mdc = 1;
    if (hook == 1) clr_at = cyc + 2;
    if (hook == 2) wr_at = cyc + 2;
    for (int k = 1; k < HALF; k++) begin
      @(negedge clk);
      evt = (hook == 1 && k == 2) ? hev : 8'h00;
    end
  endtask

  task automatic frame(input logic [4:0] phy, input logic [4:0] ra, input logic [1:0] op,
                       input logic [15:0] wd, input int pre, input logic [7:0] hev,
                       output logic [15:0] rdat, output logic ta1_oe, output logic [1:0] ta2,
                       output logic any_oe);
    logic s, o;
    logic rd, good;
    rd = (op == 2'b10);
    good = (phy == PHY) && (pre >= 32) && (op == 2'b10 || op == 2'b01);
    any_oe = 0;
    for (int i = 0; i < pre; i++) begin mbit(1, 1, 0, 0, s, o); any_oe |= o; end
    mbit(1, 0, 0, 0, s, o); any_oe |= o;
    mbit(1, 1, 0, 0, s, o); any_oe |= o;
    for (int i = 1; i >= 0; i--) begin mbit(1, op[i], 0, 0, s, o); any_oe |= o; end
    for (int i = 4; i >= 0; i--) begin mbit(1, phy[i], 0, 0, s, o); any_oe |= o; end
    for (int i = 4; i >= 0; i--) begin
      mbit(1, ra[i], (i == 0 && good && rd && ra == SRC) ? 1 : 0, hev, s, o); any_oe |= o;
    end
    mbit(!rd, 1, 0, 0, s, o); ta1_oe = o; any_oe |= o;
    mbit(!rd, 0, 0, 0, s, o); ta2 = {o, s}; any_oe |= o;
    if (good && !rd) begin wr_a = ra; wr_d = wd; end
    for (int i = 15; i >= 0; i--) begin
      mbit(!rd, wd[i], (i == 0 && good && !rd) ? 2 : 0, 0, s, o);
      rdat[i] = s; any_oe |= o;
    end
    @(negedge clk); mdc = 0; m_drv = 1; m_bit = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [4:0] ra, input logic [7:0] hev);
    logic [15:0] d, e; logic t1, ao; logic [1:0] t2;
    e = m_read(ra);
    frame(PHY, ra, 2'b10, 16'h0, 32, hev, d, t1, t2, ao);
    chk(req, {16'h0, d}, {16'h0, e});
  endtask

  task automatic wr(input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] d; logic t1, ao; logic [1:0] t2;
    frame(PHY, ra, 2'b01, wd, 32, 0, d, t1, t2, ao);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d; logic t1, ao; logic [1:0] t2;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset irq", {31'h0, irq}, 0);
    chk("reset oe", {31'h0, mdio_oe}, 0);
    // R1 reset values
    for (int a = 0; a < 7; a++) rd_chk("R1 reset value", 5'(a), 0);
    // R3 unimplemented
    rd_chk("R3 empty addr 10", 5'd10, 0);
    rd_chk("R3 empty addr 31", 5'd31, 0);
    // R11 turnaround and release
    frame(PHY, 5'd3, 2'b10, 0, 32, 0, d, t1, t2, ao);
    chk("R11 ta1 released", {31'h0, t1}, 0);
    chk("R11 ta2 drives 0", {30'h0, t2}, {30'h0, 2'b10});
    chk("R11 data", {16'h0, d}, 32'h0000C0D1);
    chk("R11 oe off after frame", {31'h0, mdio_oe}, 0);
    // R2 writable bits
    wr(5'd0, 16'hFFFF); rd_chk("R2 reg0 masked write", 5'd0, 0);
    chk("R2 reg0 value", {16'h0, m_std[0]}, 32'h0000FF80);
    wr(5'd1, 16'h0000); rd_chk("R2 reg1 read-only", 5'd1, 0);
    wr(5'd4, 16'hA5A5); rd_chk("R2 reg4", 5'd4, 0);
    // R7 mask
    wr(MSK, 16'hFFFF); rd_chk("R7 mask bits", MSK, 0);
    chk("R7 mask value", {16'h0, m_msk}, 32'h000000FE);
    // R4 events
    @(negedge clk); evt = 8'h10; @(negedge clk); evt = 0;
    @(negedge clk); chk("R7 irq set", {31'h0, irq}, 1);
    rd_chk("R5 src returns flag", SRC, 0);
    @(negedge clk); chk("R5 irq cleared", {31'h0, irq}, 0);
    rd_chk("R5 src cleared", SRC, 0);
    @(negedge clk); evt = 8'hFF; @(negedge clk); evt = 0;
    rd_chk("R4 all flags", SRC, 0);
    // R6 event on the clearing edge
    @(negedge clk); evt = 8'h20; @(negedge clk); evt = 0;
    rd_chk("R6 read old flags", SRC, 8'h04);
    @(negedge clk); chk("R6 irq kept", {31'h0, irq}, 1);
    rd_chk("R6 new flag kept", SRC, 0);
    // R8 source write ignored
    @(negedge clk); evt = 8'h08; @(negedge clk); evt = 0;
    wr(SRC, 16'hFFFF); rd_chk("R8 src unchanged", SRC, 0);
    // R7 masked source gives no irq
    wr(MSK, 16'h0002);
    @(negedge clk); evt = 8'h40; @(negedge clk); evt = 0;
    @(negedge clk); chk("R7 masked no irq", {31'h0, irq}, 0);
    // R9 foreign PHY address
    frame(5'd2, 5'd4, 2'b01, 16'h0000, 32, 0, d, t1, t2, ao);
    rd_chk("R9 reg4 untouched", 5'd4, 0);
    frame(5'd2, 5'd1, 2'b10, 0, 32, 0, d, t1, t2, ao);
    chk("R9 no drive", {31'h0, ao}, 0);
    // R10 bad opcode / short preamble
    frame(PHY, 5'd4, 2'b11, 16'h0000, 32, 0, d, t1, t2, ao);
    chk("R10 opcode 11 no drive", {31'h0, ao}, 0);
    frame(PHY, 5'd4, 2'b00, 16'h0000, 32, 0, d, t1, t2, ao);
    rd_chk("R10 opcode 00 no write", 5'd4, 0);
    frame(PHY, 5'd1, 2'b10, 0, 31, 0, d, t1, t2, ao);
    chk("R10 short preamble", {31'h0, ao}, 0);
    rd_chk("R10 recovers", 5'd2, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule